// File: doc/BRIEF.md
# Single-Accumulator Twelve-Bit Processor Core

This block is a small sequential processor. It has one architectural data register, the accumulator, and a nine-bit program counter. Every instruction word is twelve bits long: a three-bit opcode picks one of eight operations, and a nine-bit argument field follows it. Depending on the opcode, that field is a memory address, a device number, or unused. All arithmetic passes through the accumulator. The classic sequence clear, add A, add B, store C leaves A+B in location C.

The core connects to one word-addressed memory with a synchronous read port and a synchronous write port. A read request made in one cycle returns its data on `mem_rdata` in the next cycle. An output instruction does not drive real devices. It raises a one-cycle strobe with the argument as device number and the accumulator as data.

A controller built around the state machine steps through these states:
- `ST_FETCH`, which reads the word at the program counter.
- `ST_DECODE`, which latches the instruction.
- `ST_EXEC`, which carries out the opcode or issues the operand read.
- `ST_WBACK`, used only by memory-operand opcodes. It consumes the read data and may write memory.
- `ST_HALT`, which has no exit except reset.

The state machine takes these transitions:
- `FETCH->DECODE` and `DECODE->EXEC` always.
- `EXEC->WBACK` for AND, ADD and ISZ.
- `EXEC->FETCH` for STO, JMP, IOS and CLR.
- `EXEC->HALT` for HLT.
- `WBACK->FETCH` always.
- `HALT->HALT` always.

A `done` pulse marks the last cycle of every instruction.

Top module: `acc_core12`

## Requirements
- R1: The opcode sits in instruction bits [11:9] and the argument in bits [8:0]. The opcode codes are: 0 AND, 1 ADD, 2 ISZ, 3 STO, 4 JMP, 5 IOS, 6 CLR, 7 HLT.
- R2: CLR (6) sets the accumulator to zero whatever its argument, and it makes no data access.
- R3: ADD (1) sets the accumulator to accumulator + M[arg], modulo 4096.
- R4: AND (0) sets the accumulator to the bitwise AND of the accumulator and M[arg].
- R5: STO (3) writes the accumulator to M[arg] and leaves the accumulator unchanged.
- R6: ISZ (2) writes M[arg]+1 (modulo 4096) back to M[arg]. When that result is zero, the next instruction is skipped (pc+2). Otherwise pc advances by 1.
- R7: JMP (4) loads the program counter with the argument.
- R8: IOS (5) raises `io_stb` for exactly one cycle, with `io_dev` = arg and `io_data` = accumulator. `io_stb` is low at all other times.
- R9: HLT (7) freezes the program counter. After its `done` pulse there are no further memory accesses and no further `done` pulses until reset.
- R10: Reset clears the accumulator and the program counter. The first cycle after reset reads address 0.
- R11: AND, ADD and ISZ take 4 cycles. All other opcodes take 3 cycles. `done` is high in the last cycle only. The program counter advances by 1 (wrapping at 512) unless a jump, skip or halt applies.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 9 | Memory word address |
| mem_rd | output | 1 | Read request; data returns next cycle |
| mem_wr | output | 1 | Write strobe, taken at the clock edge |
| mem_wdata | output | 12 | Write data |
| mem_rdata | input | 12 | Read data from the previous cycle's request |
| io_stb | output | 1 | Output-instruction strobe |
| io_dev | output | 9 | Device number for the strobe |
| io_data | output | 12 | Accumulator value presented with the strobe |
| done | output | 1 | High in the final cycle of each instruction |
| acc_q | output | 12 | Accumulator |
| pc_q | output | 9 | Program counter |

## Verification
A behavioural instruction-level model in the bench tracks the accumulator, the program counter and a copy of memory, and it is compared with the core on every clock. The bench targets several corner cases:
- Accumulator wrap on ADD. A carry handled wrongly would leave the accumulator at 0x1001 truncated to the wrong value, or wrong in bit 11.
- ISZ at both outcomes, including the 0xFFF to 0 rollover. A core that tested the old value, or skipped by the wrong amount, would run the loop body once too often or land on a jump.
- Program-counter wrap from 511 to 0 and a jump into the top of the address space. A mis-sized counter would fetch outside the program.
- Halt. A core that kept fetching, or kept pulsing `done`, shows up in the per-cycle idle check.
- Instruction length. A wrong cycle count for memory-operand opcodes, a stray strobe, or a store of the wrong data is caught at the `done` cycle of each instruction.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int OPC_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_AND = 3'd0,
        OP_ADD = 3'd1,
        OP_ISZ = 3'd2,
        OP_STO = 3'd3,
        OP_JMP = 3'd4,
        OP_IOS = 3'd5,
        OP_CLR = 3'd6,
        OP_HLT = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_WBACK,
        ST_HALT
    } state_e;

    typedef enum logic [1:0] {
        ACC_HOLD,
        ACC_CLEAR,
        ACC_ADD,
        ACC_AND
    } acc_op_e;

    typedef enum logic [1:0] {
        PC_HOLD,
        PC_STEP,
        PC_SKIP,
        PC_JUMP
    } pc_op_e;

endpackage

// File: rtl/acc_core_fsm.sv
module acc_core_fsm
    import acc_core_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  opcode_e opcode_i,
    input  logic    inc_zero_i,
    output logic    ir_load_o,
    output acc_op_e acc_op_o,
    output pc_op_e  pc_op_o,
    output logic    addr_from_pc_o,
    output logic    wdata_inc_o,
    output logic    mem_rd_o,
    output logic    mem_wr_o,
    output logic    io_stb_o,
    output logic    done_o
);

    state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d        = state_q;
        ir_load_o      = 1'b0;
        acc_op_o       = ACC_HOLD;
        pc_op_o        = PC_HOLD;
        addr_from_pc_o = 1'b0;
        wdata_inc_o    = 1'b0;
        mem_rd_o       = 1'b0;
        mem_wr_o       = 1'b0;
        io_stb_o       = 1'b0;
        done_o         = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                mem_rd_o       = 1'b1;
                addr_from_pc_o = 1'b1;
                state_d        = ST_DECODE;
            end
            ST_DECODE: begin
                ir_load_o = 1'b1;
                state_d   = ST_EXEC;
            end
            ST_EXEC: begin
                unique case (opcode_i)
                    OP_AND, OP_ADD, OP_ISZ: begin
                        mem_rd_o = 1'b1;
                        state_d  = ST_WBACK;
                    end
                    OP_STO: begin
                        mem_wr_o = 1'b1;
                        pc_op_o  = PC_STEP;
                        done_o   = 1'b1;
                        state_d  = ST_FETCH;
                    end
                    OP_JMP: begin
                        pc_op_o = PC_JUMP;
                        done_o  = 1'b1;
                        state_d = ST_FETCH;
                    end
                    OP_IOS: begin
                        io_stb_o = 1'b1;
                        pc_op_o  = PC_STEP;
                        done_o   = 1'b1;
                        state_d  = ST_FETCH;
                    end
                    OP_CLR: begin
                        acc_op_o = ACC_CLEAR;
                        pc_op_o  = PC_STEP;
                        done_o   = 1'b1;
                        state_d  = ST_FETCH;
                    end
                    OP_HLT: begin
                        done_o  = 1'b1;
                        state_d = ST_HALT;
                    end
                    default: state_d = ST_FETCH;
                endcase
            end
            ST_WBACK: begin
                done_o  = 1'b1;
                pc_op_o = PC_STEP;
                state_d = ST_FETCH;
                unique case (opcode_i)
                    OP_AND: acc_op_o = ACC_AND;
                    OP_ADD: acc_op_o = ACC_ADD;
                    OP_ISZ: begin
                        mem_wr_o    = 1'b1;
                        wdata_inc_o = 1'b1;
                        pc_op_o     = inc_zero_i ? PC_SKIP : PC_STEP;
                    end
                    default: acc_op_o = ACC_HOLD;
                endcase
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
            default: state_d = ST_FETCH;
        endcase
    end

    assert_rw_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> (state_q == ST_HALT && !mem_rd_o && !done_o));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_then_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && opcode_i != OP_HLT) |=> (mem_rd_o && addr_from_pc_o));

endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
    import acc_core_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic [WORD_W-1:0] acc_i,
    input  logic [WORD_W-1:0] rdata_i,
    input  acc_op_e           acc_op_i,
    output logic [WORD_W-1:0] acc_nxt_o,
    output logic [WORD_W-1:0] inc_val_o,
    output logic              inc_zero_o
);

    always_comb begin
        unique case (acc_op_i)
            ACC_HOLD:  acc_nxt_o = acc_i;
            ACC_CLEAR: acc_nxt_o = '0;
            ACC_ADD:   acc_nxt_o = acc_i + rdata_i;
            ACC_AND:   acc_nxt_o = acc_i & rdata_i;
            default:   acc_nxt_o = acc_i;
        endcase
    end

    assign inc_val_o  = rdata_i + WORD_W'(1);
    assign inc_zero_o = (inc_val_o == '0);

endmodule

// File: rtl/acc_core_regs.sv
module acc_core_regs
    import acc_core_pkg::*;
#(
    parameter int WORD_W   = 12,
    parameter int ARG_W    = 9,
    parameter int RESET_PC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_load_i,
    input  logic [WORD_W-1:0] ir_in_i,
    input  logic [WORD_W-1:0] acc_nxt_i,
    input  pc_op_e            pc_op_i,
    output logic [WORD_W-1:0] ir_q,
    output logic [WORD_W-1:0] acc_q,
    output logic [ARG_W-1:0]  pc_q
);

    logic [ARG_W-1:0] pc_d;

    always_comb begin
        unique case (pc_op_i)
            PC_HOLD: pc_d = pc_q;
            PC_STEP: pc_d = pc_q + ARG_W'(1);
            PC_SKIP: pc_d = pc_q + ARG_W'(2);
            PC_JUMP: pc_d = ir_q[ARG_W-1:0];
            default: pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q  <= '0;
            acc_q <= '0;
            pc_q  <= ARG_W'(RESET_PC);
        end else begin
            if (ir_load_i) begin
                ir_q <= ir_in_i;
            end
            acc_q <= acc_nxt_i;
            pc_q  <= pc_d;
        end
    end

    assert_pc_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op_i == PC_STEP) |=> (pc_q == $past(pc_q) + ARG_W'(1)));

    assert_pc_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op_i == PC_JUMP) |=> (pc_q == $past(ir_q[ARG_W-1:0])));

    assert_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op_i == PC_HOLD) |=> $stable(pc_q));

endmodule

// File: rtl/acc_core12.sv
module acc_core12
    import acc_core_pkg::*;
#(
    parameter int WORD_W   = 12,
    parameter int RESET_PC = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic [WORD_W-OPC_W-1:0] mem_addr,
    output logic                    mem_rd,
    output logic                    mem_wr,
    output logic [WORD_W-1:0]       mem_wdata,
    input  logic [WORD_W-1:0]       mem_rdata,
    output logic                    io_stb,
    output logic [WORD_W-OPC_W-1:0] io_dev,
    output logic [WORD_W-1:0]       io_data,
    output logic                    done,
    output logic [WORD_W-1:0]       acc_q,
    output logic [WORD_W-OPC_W-1:0] pc_q
);

    localparam int ARG_W = WORD_W - OPC_W;

    logic [WORD_W-1:0] ir_q;
    logic [WORD_W-1:0] acc_nxt;
    logic [WORD_W-1:0] inc_val;
    logic              inc_zero;
    logic              ir_load;
    logic              addr_from_pc;
    logic              wdata_inc;
    acc_op_e           acc_op;
    pc_op_e            pc_op;
    opcode_e           opcode;

    assign opcode = opcode_e'(ir_q[WORD_W-1 -: OPC_W]);

    acc_core_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .opcode_i       (opcode),
        .inc_zero_i     (inc_zero),
        .ir_load_o      (ir_load),
        .acc_op_o       (acc_op),
        .pc_op_o        (pc_op),
        .addr_from_pc_o (addr_from_pc),
        .wdata_inc_o    (wdata_inc),
        .mem_rd_o       (mem_rd),
        .mem_wr_o       (mem_wr),
        .io_stb_o       (io_stb),
        .done_o         (done)
    );

    acc_core_alu #(.WORD_W(WORD_W)) u_alu (
        .acc_i      (acc_q),
        .rdata_i    (mem_rdata),
        .acc_op_i   (acc_op),
        .acc_nxt_o  (acc_nxt),
        .inc_val_o  (inc_val),
        .inc_zero_o (inc_zero)
    );

    acc_core_regs #(
        .WORD_W   (WORD_W),
        .ARG_W    (ARG_W),
        .RESET_PC (RESET_PC)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ir_load_i (ir_load),
        .ir_in_i   (mem_rdata),
        .acc_nxt_i (acc_nxt),
        .pc_op_i   (pc_op),
        .ir_q      (ir_q),
        .acc_q     (acc_q),
        .pc_q      (pc_q)
    );

    assign mem_addr  = addr_from_pc ? pc_q : ir_q[ARG_W-1:0];
    assign mem_wdata = wdata_inc ? inc_val : acc_q;
    assign io_dev    = ir_q[ARG_W-1:0];
    assign io_data   = acc_q;

    assert_store_keeps_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !wdata_inc) |=> $stable(acc_q));

endmodule

// File: tb/acc_core12_tb_top.sv
module acc_core12_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  mem_addr;
    logic        mem_rd, mem_wr, io_stb, done;
    logic [11:0] mem_wdata, io_data, acc_q;
    logic [11:0] mem_rdata = '0;
    logic [8:0]  io_dev, pc_q;

    logic [11:0] mem     [DEPTH];
    logic [11:0] ref_mem [DEPTH];

    logic [11:0] m_acc;
    logic [8:0]  m_pc;
    bit          m_halt;
    string       last_tag;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_core12 dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .io_stb(io_stb), .io_dev(io_dev), .io_data(io_data), .done(done),
        .acc_q(acc_q), .pc_q(pc_q)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R4";
            3'd1: return "R3";
            3'd2: return "R6";
            3'd3: return "R5";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R2";
            default: return "R9";
        endcase
    endfunction

    task automatic wipe();
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= '0;
            ref_mem[i] = '0;
        end
    endtask

    task automatic put(input int a, input logic [11:0] w);
        mem[a] <= w;
        ref_mem[a] = w;
    endtask

    function automatic logic [11:0] ins(input logic [2:0] op, input int arg);
        return {op, 9'(arg)};
    endfunction

    // Reset, release, then compare against the reference model every clock.
    task automatic run_program();
        int  cyc = 0;
        int  after_halt = 0;
        bit  first = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(acc_q == 12'h000, "R10", "acc in reset", acc_q, 0);
        chk(pc_q == 9'h000, "R10", "pc in reset", pc_q, 0);
        chk(!done && !mem_wr && !io_stb, "R10", "idle in reset", {done, mem_wr, io_stb}, 0);
        m_acc = '0; m_pc = '0; m_halt = 1'b0; last_tag = "R10";
        @(posedge clk);
        #1 rst_n = 1'b1;
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            cyc++;
            if (first) begin
                chk(mem_rd && mem_addr == 9'd0, "R10", "first fetch", {mem_rd, mem_addr}, 10'h200);
                first = 1'b0;
            end
            chk(acc_q == m_acc, last_tag, "accumulator", acc_q, m_acc);
            chk(pc_q == m_pc, last_tag, "program counter", pc_q, m_pc);
            chk(!(mem_rd && mem_wr), "R12", "rd/wr overlap", {mem_rd, mem_wr}, 0);
            if (m_halt) begin
                chk(!done && !mem_rd && !mem_wr, "R9", "activity after halt",
                    {done, mem_rd, mem_wr}, 0);
                after_halt++;
                if (after_halt > 12) return;
            end else if (!done) begin
                chk(!io_stb && !mem_wr, "R8", "strobe/write outside last cycle",
                    {io_stb, mem_wr}, 0);
            end else begin
                logic [11:0] w;
                logic [2:0]  op;
                logic [8:0]  a;
                logic [11:0] nv;
                w  = ref_mem[m_pc];
                op = w[11:9];
                a  = w[8:0];
                last_tag = op_tag(op);
                chk(cyc == ((op <= 3'd2) ? 4 : 3), "R11", "instruction length",
                    cyc, (op <= 3'd2) ? 4 : 3);
                cyc = 0;
                case (op)
                    3'd0: begin
                        m_acc = m_acc & ref_mem[a];
                        m_pc  = m_pc + 9'd1;
                    end
                    3'd1: begin
                        m_acc = m_acc + ref_mem[a];
                        m_pc  = m_pc + 9'd1;
                    end
                    3'd2: begin
                        nv = ref_mem[a] + 12'd1;
                        chk(mem_wr && mem_addr == a, "R1", "ISZ write address", mem_addr, a);
                        chk(mem_wdata == nv, "R6", "ISZ write data", mem_wdata, nv);
                        ref_mem[a] = nv;
                        m_pc = m_pc + ((nv == 12'd0) ? 9'd2 : 9'd1);
                    end
                    3'd3: begin
                        chk(mem_wr && mem_addr == a, "R1", "STO write address", mem_addr, a);
                        chk(mem_wdata == m_acc, "R5", "STO write data", mem_wdata, m_acc);
                        ref_mem[a] = m_acc;
                        m_pc = m_pc + 9'd1;
                    end
                    3'd4: m_pc = a;
                    3'd5: begin
                        chk(io_stb, "R8", "IOS strobe", io_stb, 1);
                        chk(io_dev == a, "R8", "IOS device", io_dev, a);
                        chk(io_data == m_acc, "R8", "IOS data", io_data, m_acc);
                        m_pc = m_pc + 9'd1;
                    end
                    3'd6: begin
                        chk(!mem_rd && !mem_wr, "R2", "CLR memory access", {mem_rd, mem_wr}, 0);
                        m_acc = '0;
                        m_pc  = m_pc + 9'd1;
                    end
                    default: m_halt = 1'b1;
                endcase
                if (op != 3'd2 && op != 3'd3)
                    chk(!mem_wr, op_tag(op), "unexpected write", mem_wr, 0);
                if (op != 3'd5)
                    chk(!io_stb, "R8", "unexpected strobe", io_stb, 0);
            end
        end
        chk(1'b0, "R9", "program never halted (watchdog)", pc_q, m_pc);
    endtask

    initial begin
        // Program 1: sum of two words, CLR with a non-zero argument
        wipe();
        put(0, ins(3'd1, 103));
        put(1, ins(3'd6, 55));
        put(2, ins(3'd1, 100));
        put(3, ins(3'd1, 101));
        put(4, ins(3'd3, 102));
        put(5, ins(3'd7, 0));
        put(100, 12'h123); put(101, 12'h456); put(102, 12'h777); put(103, 12'h0F0);
        #1;
        run_program();
        chk(mem[102] == 12'h579, "R5", "C = A + B", mem[102], 12'h579);
        chk(pc_q == 9'd5, "R9", "pc frozen at halt", pc_q, 5);

        // Program 2: wrap on ADD, AND, IOS, ISZ loop with skip, far jump
        wipe();
        put(0, ins(3'd1, 200));
        put(1, ins(3'd1, 201));
        put(2, ins(3'd1, 202));
        put(3, ins(3'd0, 203));
        put(4, ins(3'd5, 9'h1A5));
        put(5, ins(3'd2, 204));
        put(6, ins(3'd4, 5));
        put(7, ins(3'd5, 3));
        put(8, ins(3'd4, 300));
        put(300, ins(3'd3, 205));
        put(301, ins(3'd7, 0));
        put(200, 12'hFFF); put(201, 12'h002); put(202, 12'hABC);
        put(203, 12'h0F0); put(204, 12'hFFD);
        #1;
        run_program();
        chk(mem[204] == 12'h000, "R6", "ISZ counter rolled to zero", mem[204], 0);
        chk(mem[205] == 12'h0B0, "R4", "AND result stored", mem[205], 12'h0B0);
        chk(acc_q == 12'h0B0, "R3", "accumulator after wrap and mask", acc_q, 12'h0B0);

        // Program 3: skip taken and not taken, pc wrap from 511 to 0
        wipe();
        put(0, ins(3'd2, 30));
        put(1, ins(3'd7, 0));
        put(2, ins(3'd4, 510));
        put(510, ins(3'd1, 20));
        put(511, ins(3'd5, 9'h1FF));
        put(30, 12'hFFF); put(20, 12'h00C);
        #1;
        run_program();
        chk(mem[30] == 12'h001, "R6", "ISZ second pass", mem[30], 1);
        chk(pc_q == 9'd1, "R11", "pc after wrap", pc_q, 1);
        chk(acc_q == 12'h00C, "R3", "accumulator", acc_q, 12'h00C);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL R9 watchdog expired: actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule